// File: doc/BRIEF.md
# Shared Second-Level Translation Lookup Arbiter

Two first-level translation caches, one for instruction fetch and one for loads and stores, share a single second-level translation array. When one of them misses, it raises a refill request and holds the page number steady. This block decides which side may look up the shared array, presents the lookup, and returns the result to that side alone. When the array hits, the result arrives at a fixed latency: four cycles for instruction fetch and three for data. When the array misses, the block reports a fault after a longer delay, and the requesting side raises its translation-miss exception.

Only one lookup is in flight at a time. If both sides ask in the same cycle, the data side wins and the instruction side stalls until the data result has been delivered. If only one side asks, it is granted in the cycle it asks. A context-synchronising flush event cancels any lookup in progress, and no response is given for it. The shared array is modelled as a port that answers within the same cycle. The latency is produced by a countdown inside this block.

The controller has three states. IDLE accepts a grant. WAIT counts down the latency. RESP delivers the result for one cycle. There are four transitions: *grant* (IDLE to WAIT, when a request is accepted and no flush is present), *expire* (WAIT to RESP, when the countdown reaches zero), *complete* (RESP to IDLE) and *cancel* (WAIT or RESP to IDLE on a flush, with the response suppressed).

Top module: `ut_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it with no request present, `ut_lookup`, `i_done` and `d_done` are all 0.
- R2: When `i_req` and `d_req` are both high in a cycle where a grant is possible, the lookup goes to the data side: `ut_side` = 1 (1 means data, 0 means instruction) and `ut_vpn` equals `d_vpn`.
- R3: An instruction request first seen in cycle c, with nothing else outstanding and a hit in the shared array, gets `i_done` high in cycle c+4 and in no other cycle.
- R4: A data request first seen in cycle c, with nothing else outstanding and a hit in the shared array, gets `d_done` high in cycle c+3 and in no other cycle.
- R5: A lone request that arrives while the block is idle and no flush is present is looked up in that same cycle: `ut_lookup` = 1, with `ut_side` and `ut_vpn` taken from that requester.
- R6: When the shared array misses (`ut_hit` = 0 during the lookup cycle), the done pulse comes 6 cycles later than the hit latency, and `rsp_miss` = 1 during it. On a hit, `rsp_miss` = 0.
- R7: After a lookup, no further lookup is issued until the response cycle of that lookup has passed. In particular, `ut_lookup` is never high in two consecutive cycles.
- R8: A flush in any cycle after the grant, up to and including the response cycle, cancels the lookup. No done pulse is produced for it, and a later request is served with its normal latency.
- R9: The done pulse goes only to the side that was granted, and `i_done` and `d_done` are never high together. On a hit, `rsp_entry` equals the `ut_entry` value that was presented in the lookup cycle.
- R10: When both sides request in cycle c, the data done comes at c+Ld, where Ld is the data latency including any miss penalty. The instruction lookup is then issued in cycle c+Ld+1, and its done comes at c+Ld+1+Li.
- R11: A flush in the cycle a request arrives at an idle block prevents the grant: `ut_lookup` stays 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Context-synchronising event; cancels the lookup in progress |
| i_req | input | 1 | Instruction-side refill request, held until done |
| i_vpn | input | VPN_W | Instruction-side page number |
| d_req | input | 1 | Data-side refill request, held until done |
| d_vpn | input | VPN_W | Data-side page number |
| ut_lookup | output | 1 | Lookup strobe to the shared array |
| ut_side | output | 1 | Side of the current lookup (1 = data) |
| ut_vpn | output | VPN_W | Page number presented to the shared array |
| ut_hit | input | 1 | Shared-array hit, valid in the lookup cycle |
| ut_entry | input | ENTRY_W | Shared-array translation, valid in the lookup cycle |
| i_done | output | 1 | Result pulse to the instruction side |
| d_done | output | 1 | Result pulse to the data side |
| rsp_miss | output | 1 | Shared-array miss indication, valid with a done pulse |
| rsp_entry | output | ENTRY_W | Translation returned with a done pulse |

## Verification
Two pairs of events can fall in the same cycle. The first is a flush and a response. The bench sweeps the flush cycle across every position from the request cycle to the response cycle, for both sides and for both hit and miss. It judges the outcome by the absence of any done pulse and by the normal latency of the next request. The second is a completion and a waiting grant. The bench drives both sides at once over a grid of page numbers that mixes hits and misses. It requires the instruction lookup to appear exactly one cycle after the data done, and computes both done cycles from the latencies and the miss penalty.

// File: rtl/ut_arb_pkg.sv
`timescale 1ns/1ps
package ut_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } arb_state_e;

    typedef enum logic {
        SIDE_INST = 1'b0,
        SIDE_DATA = 1'b1
    } side_e;

endpackage

// File: rtl/ut_arb_pick.sv
`timescale 1ns/1ps
// Chooses which side is granted. Priority is a fixed order chosen by parameter.
module ut_arb_pick #(
    parameter bit DATA_FIRST = 1'b1
) (
    input  logic             enable,
    input  logic             i_req,
    input  logic             d_req,
    output logic             grant_valid,
    output ut_arb_pkg::side_e grant_side
);
    import ut_arb_pkg::*;

    assign grant_valid = enable && (i_req || d_req);

    generate
        if (DATA_FIRST) begin : g_data_first
            assign grant_side = d_req ? SIDE_DATA : SIDE_INST;
        end else begin : g_inst_first
            assign grant_side = i_req ? SIDE_INST : SIDE_DATA;
        end
    endgenerate

endmodule

// File: rtl/ut_arb_timer.sv
`timescale 1ns/1ps
// Countdown that holds the lookup result until its latency has elapsed.
module ut_arb_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ut_arbiter.sv
`timescale 1ns/1ps
// Arbiter for the shared second-level translation array.
module ut_arbiter #(
    parameter int unsigned VPN_W    = 20,
    parameter int unsigned ENTRY_W  = 32,
    parameter int unsigned I_LAT    = 4,   // instruction hit latency, at least 2
    parameter int unsigned D_LAT    = 3,   // data hit latency, at least 2
    parameter int unsigned MISS_PEN = 6    // extra cycles on a shared-array miss
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               i_req,
    input  logic [VPN_W-1:0]   i_vpn,
    input  logic               d_req,
    input  logic [VPN_W-1:0]   d_vpn,
    output logic               ut_lookup,
    output logic               ut_side,
    output logic [VPN_W-1:0]   ut_vpn,
    input  logic               ut_hit,
    input  logic [ENTRY_W-1:0] ut_entry,
    output logic               i_done,
    output logic               d_done,
    output logic               rsp_miss,
    output logic [ENTRY_W-1:0] rsp_entry
);
    import ut_arb_pkg::*;

    localparam int unsigned MAX_HIT = (I_LAT > D_LAT) ? I_LAT : D_LAT;
    localparam int unsigned MAX_ALL = MAX_HIT + MISS_PEN;
    localparam int unsigned CNT_W   = $clog2(MAX_ALL + 1);

    arb_state_e         state_q, state_d;
    side_e              side_q;
    logic               hit_q;
    logic [ENTRY_W-1:0] entry_q;

    logic               grant_valid;
    side_e              grant_side;
    logic               expired;
    logic [CNT_W-1:0]   lat_sel;
    logic [CNT_W-1:0]   load_val;

    // Grants are only possible from IDLE and never in a flush cycle.
    ut_arb_pick #(
        .DATA_FIRST (1'b1)
    ) u_pick (
        .enable      (state_q == ST_IDLE && !flush),
        .i_req       (i_req),
        .d_req       (d_req),
        .grant_valid (grant_valid),
        .grant_side  (grant_side)
    );

    // Total latency minus the grant cycle and the response cycle.
    always_comb begin
        lat_sel = (grant_side == SIDE_DATA) ? CNT_W'(D_LAT) : CNT_W'(I_LAT);
        if (!ut_hit) begin
            lat_sel = lat_sel + CNT_W'(MISS_PEN);
        end
        load_val = lat_sel - CNT_W'(2);
    end

    ut_arb_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grant_valid),
        .load_val (load_val),
        .tick     (state_q == ST_WAIT),
        .expired  (expired)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: grant, expire, complete and cancel.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_valid) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (flush) begin
                    state_d = ST_IDLE;
                end else if (expired) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Result captured in the lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q  <= SIDE_INST;
            hit_q   <= 1'b0;
            entry_q <= '0;
        end else if (grant_valid) begin
            side_q  <= grant_side;
            hit_q   <= ut_hit;
            entry_q <= ut_entry;
        end
    end

    // Outputs.
    always_comb begin
        ut_lookup = grant_valid;
        ut_side   = (grant_side == SIDE_DATA);
        ut_vpn    = (grant_side == SIDE_DATA) ? d_vpn : i_vpn;
        i_done    = 1'b0;
        d_done    = 1'b0;
        rsp_miss  = 1'b0;
        rsp_entry = entry_q;
        unique case (state_q)
            ST_RESP: begin
                if (!flush) begin
                    i_done   = (side_q == SIDE_INST);
                    d_done   = (side_q == SIDE_DATA);
                    rsp_miss = !hit_q;
                end
            end
            ST_IDLE, ST_WAIT: begin
                rsp_miss = 1'b0;
            end
            default: begin
                rsp_miss = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ut_arbiter_chk.sv
`timescale 1ns/1ps
module ut_arbiter_chk #(
    parameter int unsigned VPN_W = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush,
    input logic                   i_req,
    input logic                   d_req,
    input logic [VPN_W-1:0]       d_vpn,
    input logic                   ut_lookup,
    input logic                   ut_side,
    input logic [VPN_W-1:0]       ut_vpn,
    input logic                   i_done,
    input logic                   d_done,
    input ut_arb_pkg::arb_state_e state_q
);
    import ut_arb_pkg::*;

    // R7
    single_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ut_lookup |=> !ut_lookup);

    // R9
    one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_done && d_done));

    // R2
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ut_lookup && d_req) |-> (ut_side && ut_vpn == d_vpn));

    // R5
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !flush && (i_req || d_req)) |-> ut_lookup);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!i_done && !d_done));

    // R8
    flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!i_done && !d_done));

    // R11
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ut_lookup);

endmodule

bind ut_arbiter ut_arbiter_chk #(
    .VPN_W (VPN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .i_req     (i_req),
    .d_req     (d_req),
    .d_vpn     (d_vpn),
    .ut_lookup (ut_lookup),
    .ut_side   (ut_side),
    .ut_vpn    (ut_vpn),
    .i_done    (i_done),
    .d_done    (d_done),
    .state_q   (state_q)
);

// File: tb/ut_arbiter_bench.sv
`timescale 1ns/1ps
module ut_arbiter_bench;
    localparam int VW = 20;
    localparam int EW = 32;
    localparam int IL = 4;
    localparam int DL = 3;
    localparam int MP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          i_req = 1'b0;
    logic [VW-1:0] i_vpn = '0;
    logic          d_req = 1'b0;
    logic [VW-1:0] d_vpn = '0;
    logic          ut_lookup, ut_side;
    logic [VW-1:0] ut_vpn;
    logic          ut_hit;
    logic [EW-1:0] ut_entry;
    logic          i_done, d_done, rsp_miss;
    logic [EW-1:0] rsp_entry;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ut_arbiter #(
        .VPN_W (VW), .ENTRY_W (EW), .I_LAT (IL), .D_LAT (DL), .MISS_PEN (MP)
    ) u_ut_arbiter (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .i_req (i_req), .i_vpn (i_vpn), .d_req (d_req), .d_vpn (d_vpn),
        .ut_lookup (ut_lookup), .ut_side (ut_side), .ut_vpn (ut_vpn),
        .ut_hit (ut_hit), .ut_entry (ut_entry),
        .i_done (i_done), .d_done (d_done),
        .rsp_miss (rsp_miss), .rsp_entry (rsp_entry)
    );

    // Shared-array model: a page hits unless its number is a multiple of 3.
    function automatic logic hit_of(input logic [VW-1:0] v);
        return (v % 3) != 0;
    endfunction

    function automatic logic [EW-1:0] ent_of(input logic [VW-1:0] v);
        logic [VW-1:0] m;
        m = v * 7;
        return {v ^ 20'h5A5A5, m[11:0]};
    endfunction

    function automatic int lat_of(input bit side, input logic [VW-1:0] v);
        return (side ? DL : IL) + (hit_of(v) ? 0 : MP);
    endfunction

    always_comb begin
        ut_hit   = hit_of(ut_vpn);
        ut_entry = ent_of(ut_vpn);
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic set_req(input bit side, input bit val, input logic [VW-1:0] v);
        if (side) begin d_req = val; d_vpn = v; end
        else      begin i_req = val; i_vpn = v; end
    endtask

    // Lone request; entered and left at 1 ns after a rising edge.
    task automatic single(input bit side, input logic [VW-1:0] v);
        int  lat;
        int  got;
        bit  bad_other;
        bit  bad_look;
        lat = lat_of(side, v);
        got = -1;
        bad_other = 1'b0;
        bad_look = 1'b0;
        set_req(side, 1'b1, v);
        #1;
        check(ut_lookup && ut_side == side && ut_vpn == v, "R5", "same-cycle lookup",
              {ut_lookup, ut_side}, {1'b1, side});
        for (int n = 1; n <= 40 && got < 0; n++) begin
            @(posedge clk); #1; #1;
            if (side ? i_done : d_done) bad_other = 1'b1;
            if (ut_lookup) bad_look = 1'b1;
            if (side ? d_done : i_done) begin
                got = n;
                check(n == lat, side ? "R4" : "R3", "done cycle", n, lat);
                check(rsp_miss == !hit_of(v), "R6", "miss flag", rsp_miss, !hit_of(v));
                if (hit_of(v))
                    check(rsp_entry == ent_of(v), "R9", "entry", rsp_entry, ent_of(v));
            end
        end
        check(got >= 0, side ? "R4" : "R3", "done seen", got, lat);
        check(!bad_other, "R9", "wrong-side done", bad_other, 0);
        check(!bad_look, "R7", "extra lookup", bad_look, 0);
        @(posedge clk); #1;
        set_req(side, 1'b0, v);
    endtask

    // Both sides request together.
    task automatic both(input logic [VW-1:0] iv, input logic [VW-1:0] dv);
        int ld;
        int li;
        int dn;
        int inn;
        bit drop_d;
        ld = lat_of(1'b1, dv);
        li = lat_of(1'b0, iv);
        dn = -1;
        inn = -1;
        drop_d = 1'b0;
        set_req(1'b0, 1'b1, iv);
        set_req(1'b1, 1'b1, dv);
        #1;
        check(ut_lookup && ut_side && ut_vpn == dv, "R2", "data wins",
              ut_side, 1);
        for (int n = 1; n <= 60 && inn < 0; n++) begin
            @(posedge clk); #1;
            if (drop_d) begin d_req = 1'b0; drop_d = 1'b0; end
            #1;
            if (n == ld + 1)
                check(ut_lookup && !ut_side && ut_vpn == iv, "R10", "inst grant after data",
                      {ut_lookup, ut_side}, 2'b10);
            if (d_done) begin dn = n; drop_d = 1'b1; end
            if (i_done) begin
                inn = n;
                check(rsp_miss == !hit_of(iv), "R6", "inst miss flag", rsp_miss, !hit_of(iv));
            end
        end
        check(dn == ld, "R2", "data done cycle", dn, ld);
        check(inn == ld + 1 + li, "R10", "inst done cycle", inn, ld + 1 + li);
        @(posedge clk); #1;
        i_req = 1'b0;
        d_req = 1'b0;
    endtask

    // Flush k cycles after the request (k = 0: same cycle).
    task automatic flush_at(input bit side, input logic [VW-1:0] v, input int k);
        int lat;
        bit seen;
        lat = lat_of(side, v);
        seen = 1'b0;
        set_req(side, 1'b1, v);
        if (k == 0) flush = 1'b1;
        #1;
        if (k == 0) begin
            check(!ut_lookup, "R11", "grant blocked by flush", ut_lookup, 0);
            @(posedge clk); #1;
            flush = 1'b0;
            set_req(side, 1'b0, v);
        end
        for (int n = 1; n <= lat + 4; n++) begin
            if (k != 0) begin
                @(posedge clk); #1;
                if (n == k) begin flush = 1'b1; set_req(side, 1'b0, v); end
                else flush = 1'b0;
            end else begin
                @(posedge clk); #1;
            end
            #1;
            if (i_done || d_done) seen = 1'b1;
        end
        flush = 1'b0;
        check(!seen, k == 0 ? "R11" : "R8", "done after cancel", seen, 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; #1;
        check(!ut_lookup && !i_done && !d_done, "R1", "outputs in reset",
              {ut_lookup, i_done, d_done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        check(!ut_lookup && !i_done && !d_done, "R1", "outputs after reset",
              {ut_lookup, i_done, d_done}, 0);
        @(posedge clk); #1;

        for (int s = 0; s < 2; s++)
            for (int v = 0; v < 12; v++)
                single(s[0], VW'(v + 40 * s));

        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                both(VW'(100 + a), VW'(200 + b));

        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 2; h++) begin
                logic [VW-1:0] v;
                v = h ? VW'(7) : VW'(9);
                for (int k = 0; k <= lat_of(s[0], v); k++) begin
                    flush_at(s[0], v, k);
                    single(s[0], VW'(5 + k));   // R8: normal service after cancel
                end
            end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule